// File: doc/BRIEF.md
# ARINC 429 Serial Word Transmitter with Transmit Queue

This block accepts 32-bit ARINC 429 words from a 16-bit host bus and sends them out serially. The host supplies each word in two writes: one strobe captures the low half, and a second strobe supplies the high half and commits the whole word to an eight-entry queue. While the transmit enable is held high, the block takes words off the queue one at a time. It sends each one least significant bit first as return-to-zero pulses on a pair of outputs, one output for logic one and one for logic zero. The word's top bit is replaced by a parity bit whose sense is set by a control input.

A single status output stays high while nothing is queued and nothing is on the wire. It drops the cycle after a word is committed. It rises again only after the last queued word and its inter-word null gap have gone out. A rate select picks one of two bit periods, with an 8:1 ratio between them. A loopback control steers the serial pulses onto a second output pair that feeds an on-chip receiver; in that mode the line pair stays at null.

Top module: `a429_xmit`

## Requirements
- R1: A high on `ld_lo` captures `host_d` as word bits 15:0. A high on `ld_hi` takes `host_d` as bits 31:16 and writes the assembled word into the queue.
- R2: `tx_ready` is 0 in the cycle after a write that the queue accepts.
- R3: `tx_ready` returns to 1 only when the queue is empty and the last word, including its null gap, has been sent. It stays 0 while words are pending or a gap is running.
- R4: The last transmitted bit is parity over bits 30:0. With `par_even`=0 the 32 sent bits have odd total parity; with `par_even`=1 they have even total parity.
- R5: Bits go out in the order bit 0 through bit 30, then parity. A 1 pulses `*_one` and a 0 pulses `*_zero`, and the two are never high together.
- R6: Each bit is active for one half period, then null (both outputs low) for one half period of equal length.
- R7: Between the end of one word's last active half and the next word's first pulse there are at least 4.5 bit times of null.
- R8: The queue holds 8 words. `fifo_full` is 1 while 8 are held, and a write while full is dropped and never sent.
- R9: With `rate_slow`=0 a half period lasts DIV_FAST (default 2) clocks. With `rate_slow`=1 it lasts DIV_SLOW (default 16) clocks.
- R10: With `loop_n`=0 the pulses appear on `lb_one`/`lb_zero` and the line pair stays low. With `loop_n`=1 the roles are reversed.
- R11: Out of reset `tx_ready`=1, `fifo_full`=0 and all serial outputs are low. Queued words are held and not sent while `xmit_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_d | input | 16 | Host data half-word |
| ld_lo | input | 1 | Capture low half |
| ld_hi | input | 1 | Capture high half and commit word |
| xmit_en | input | 1 | Allow transmission |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| loop_n | input | 1 | 0 routes serial data to the loopback pair |
| rate_slow | input | 1 | Selects the long bit period |
| line_one | output | 1 | Line "one" pulse |
| line_zero | output | 1 | Line "zero" pulse |
| lb_one | output | 1 | Loopback "one" pulse |
| lb_zero | output | 1 | Loopback "zero" pulse |
| tx_ready | output | 1 | High when idle with queue empty |
| fifo_full | output | 1 | Queue holds 8 words |

## Verification
A corrupt queue pointer shows up as a repeated, missing or stale word in the decoded serial stream. It appears on the first word sent after the fault, within about 40 bit times. A wrong bit or state counter in the shifter makes a word too short or too long, a pulse of the wrong width, or a null gap that is too short. The decoder on the output pair catches these within the affected word. A status flag that tracks the queue but not the shifter rises during the gap, and this is caught at the instant the last active half ends.

// File: rtl/a429_pkg.sv
package a429_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_BIT  = 2'd1,
        SER_GAP  = 2'd2
    } ser_st_e;

    // parity bit for the top position; even_sel=0 gives odd total parity
    function automatic logic par_bit(input logic [WORD_W-2:0] d, input logic even_sel);
        return even_sel ? (^d) : ~(^d);
    endfunction
endpackage

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
    parameter int DEPTH = 8,   // power of two
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wp;
        logic [AW:0]             rp;
    } fifo_t;

    fifo_t st_d, st_q;

    assign empty = (st_q.wp == st_q.rp);
    assign full  = (st_q.wp[AW] != st_q.rp[AW]) && (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
    assign rdata = st_q.mem[st_q.rp[AW-1:0]];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.mem[st_q.wp[AW-1:0]] = wdata;
            st_d.wp = st_q.wp + (AW+1)'(1);
        end
        if (pop && !empty) begin
            st_d.rp = st_q.rp + (AW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FULL_DROPS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(st_q.wp)); // R8

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R11
endmodule

// File: rtl/a429_half_timer.sv
module a429_half_timer #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 16   // must be >= DIV_FAST
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow,
    output logic tick
);
    localparam int CW = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    assign lim  = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    assign tick = !clr && (cnt_q >= lim);

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/a429_shifter.sv
module a429_shifter
    import a429_pkg::*;
#(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 16,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_en,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_head,
    input  logic              par_even,
    input  logic              rate_slow,
    output logic              q_pop,
    output logic              out_one,
    output logic              out_zero,
    output logic              busy
);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int GW         = $clog2(GAP_HALVES + 1);
    localparam int BW         = $clog2(WORD_W);

    typedef struct packed {
        ser_st_e           st;
        logic [WORD_W-1:0] sh;
        logic [BW-1:0]     bitn;
        logic              nul;
        logic [GW-1:0]     gap;
    } ser_t;

    ser_t s_d, s_q;
    logic tick;
    logic tmr_clr;
    logic act;
    logic head_msb_unused;

    assign head_msb_unused = q_head[WORD_W-1];
    assign tmr_clr         = (s_q.st == SER_IDLE);

    a429_half_timer #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .slow  (rate_slow),
        .tick  (tick)
    );

    always_comb begin
        s_d   = s_q;
        q_pop = 1'b0;
        unique case (s_q.st)
            SER_IDLE: begin
                if (go_en && !q_empty) begin
                    q_pop    = 1'b1;
                    s_d.st   = SER_BIT;
                    s_d.sh   = {par_bit(q_head[WORD_W-2:0], par_even), q_head[WORD_W-2:0]};
                    s_d.bitn = '0;
                    s_d.nul  = 1'b0;
                end
            end
            SER_BIT: begin
                if (tick) begin
                    if (!s_q.nul) begin
                        s_d.nul = 1'b1;
                    end else begin
                        s_d.nul = 1'b0;
                        s_d.sh  = s_q.sh >> 1;
                        if (s_q.bitn == BW'(WORD_W - 1)) begin
                            s_d.st  = SER_GAP;
                            s_d.gap = '0;
                        end else begin
                            s_d.bitn = s_q.bitn + BW'(1);
                        end
                    end
                end
            end
            SER_GAP: begin
                if (tick) begin
                    if (s_q.gap == GW'(GAP_HALVES - 1)) s_d.st  = SER_IDLE;
                    else                                s_d.gap = s_q.gap + GW'(1);
                end
            end
            default: s_d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act      = (s_q.st == SER_BIT) && !s_q.nul;
    assign out_one  = act &&  s_q.sh[0];
    assign out_zero = act && !s_q.sh[0];
    assign busy     = (s_q.st != SER_IDLE);

    AST_PARITY_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SER_BIT && $past(s_q.st) == SER_IDLE) |-> ((^s_q.sh) == !$past(par_even))); // R4

    AST_RETURN_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_one || out_zero) && tick) |=> !(out_one || out_zero)); // R6
endmodule

// File: rtl/a429_xmit.sv
module a429_xmit
    import a429_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 16,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] host_d,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              xmit_en,
    input  logic              par_even,
    input  logic              loop_n,
    input  logic              rate_slow,
    output logic              line_one,
    output logic              line_zero,
    output logic              lb_one,
    output logic              lb_zero,
    output logic              tx_ready,
    output logic              fifo_full
);
    typedef struct packed {
        logic [HALF_W-1:0] lo;
    } hold_t;

    hold_t h_d, h_q;

    logic              q_empty;
    logic              q_pop;
    logic [WORD_W-1:0] q_head;
    logic [WORD_W-1:0] q_word;
    logic              ser_one;
    logic              ser_zero;
    logic              ser_busy;

    always_comb begin
        h_d = h_q;
        if (ld_lo) h_d.lo = host_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign q_word = {host_d, h_q.lo};

    a429_word_fifo #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ld_hi),
        .wdata (q_word),
        .pop   (q_pop),
        .rdata (q_head),
        .empty (q_empty),
        .full  (fifo_full)
    );

    a429_shifter #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW),
        .GAP_BITS (GAP_BITS)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_en     (xmit_en),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .par_even  (par_even),
        .rate_slow (rate_slow),
        .q_pop     (q_pop),
        .out_one   (ser_one),
        .out_zero  (ser_zero),
        .busy      (ser_busy)
    );

    assign line_one  = loop_n  && ser_one;
    assign line_zero = loop_n  && ser_zero;
    assign lb_one    = !loop_n && ser_one;
    assign lb_zero   = !loop_n && ser_zero;
    assign tx_ready  = q_empty && !ser_busy;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !fifo_full) |=> !tx_ready); // R2

    AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_one && line_zero) && !(lb_one && lb_zero)); // R5
endmodule

// File: tb/sim_a429_xmit.sv
`timescale 1ns/1ps
module sim_a429_xmit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_d = '0;
    logic        ld_lo = 1'b0, ld_hi = 1'b0, xmit_en = 1'b0;
    logic        par_even = 1'b0, loop_n = 1'b1, rate_slow = 1'b0;
    logic        line_one, line_zero, lb_one, lb_zero, tx_ready, fifo_full;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    a429_xmit u0 (
        .clk(clk), .rst_n(rst_n), .host_d(host_d), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .xmit_en(xmit_en), .par_even(par_even), .loop_n(loop_n), .rate_slow(rate_slow),
        .line_one(line_one), .line_zero(line_zero), .lb_one(lb_one), .lb_zero(lb_zero),
        .tx_ready(tx_ready), .fifo_full(fifo_full)
    );

    // ---------------- serial decoder ----------------
    int          nw = 0;
    logic [31:0] wbuf [0:63];
    int          bitn = 0, act_run = 0, null_run = 0;
    logic [31:0] cur = '0;
    bit          prev_act = 0, have_prev = 0, sel_lb = 0;
    int          width_err = 0, gap_err = 0, both_err = 0, leak = 0;
    int          half_exp = 2;
    logic        mo, mz, xo, xz;

    always @(negedge clk) begin
        if (rst_n) begin
            mo = sel_lb ? lb_one  : line_one;
            mz = sel_lb ? lb_zero : line_zero;
            xo = sel_lb ? line_one : lb_one;
            xz = sel_lb ? line_zero : lb_zero;
            if (mo && mz) both_err++;
            if (xo || xz) leak++;
            if (mo || mz) begin
                if (!prev_act) begin
                    if (bitn == 0 && have_prev && null_run < 9 * half_exp) gap_err++;
                    cur = {mo, cur[31:1]};
                    bitn++;
                    act_run = 1;
                end else begin
                    act_run++;
                end
                null_run = 0;
                prev_act = 1;
            end else begin
                if (prev_act) begin
                    if (act_run != half_exp) width_err++;
                    if (bitn == 32) begin
                        if (nw < 64) wbuf[nw] = cur;
                        nw++;
                        bitn = 0;
                        have_prev = 1;
                    end
                end
                null_run++;
                prev_act = 0;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] exp_word(input logic [31:0] w, input logic ev);
        logic p;
        p = ev ? (^w[30:0]) : ~(^w[30:0]);
        return {p, w[30:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_word(input logic [31:0] w);
        host_d = w[15:0]; ld_lo = 1'b1;
        cyc(1);
        ld_lo = 1'b0; host_d = w[31:16]; ld_hi = 1'b1;
        cyc(1);
        ld_hi = 1'b0; host_d = '0;
    endtask

    task automatic wait_ready(input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (tx_ready) begin ok = 1; break; end
        end
    endtask

    task automatic wait_words(input int target, input int lim, output bit ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (nw >= target) begin ok = 1; break; end
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(tx_ready == 1'b1, "R11 ready after reset", 32'(tx_ready), 32'd1);
        check(fifo_full == 1'b0, "R11 full after reset", 32'(fifo_full), 32'd0);
        check({line_one, line_zero, lb_one, lb_zero} == 4'b0, "R11 outputs null after reset",
              32'({line_one, line_zero, lb_one, lb_zero}), 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] w = 32'h8123_45A6;
        int base = nw, werr = width_err;
        bit ok;
        xmit_en = 1'b0; par_even = 1'b0; half_exp = 2;
        load_word(w);
        @(negedge clk);
        check(tx_ready == 1'b0, "R2 ready low after write", 32'(tx_ready), 32'd0);
        cyc(60);
        check(nw == base, "R11 nothing sent while disabled", 32'(nw - base), 32'd0);
        xmit_en = 1'b1;
        wait_ready(2000, ok);
        check(ok && nw == base + 1, "R1 one word sent", 32'(nw - base), 32'd1);
        check(wbuf[base] == exp_word(w, 1'b0), "R1 R5 R4 word content odd parity", wbuf[base], exp_word(w, 1'b0));
        check(width_err == werr, "R6 R9 active half width fast", 32'(width_err - werr), 32'd0);
    endtask

    task automatic t_even_pair();
        logic [31:0] wa = 32'h0000_0001, wb = 32'hFFFF_FFFF;
        int base = nw, gerr = gap_err;
        bit ok;
        xmit_en = 1'b0; par_even = 1'b1;
        load_word(wa);
        load_word(wb);
        xmit_en = 1'b1;
        wait_words(base + 1, 2000, ok);
        check(ok && tx_ready == 1'b0, "R3 ready low while word pending", 32'(tx_ready), 32'd0);
        wait_words(base + 2, 2000, ok);
        check(ok && tx_ready == 1'b0, "R3 ready low during final gap", 32'(tx_ready), 32'd0);
        wait_ready(2000, ok);
        check(ok, "R3 ready returns after last word", 32'(ok), 32'd1);
        check(wbuf[base] == exp_word(wa, 1'b1), "R4 even parity word a", wbuf[base], exp_word(wa, 1'b1));
        check(wbuf[base+1] == exp_word(wb, 1'b1), "R4 even parity word b", wbuf[base+1], exp_word(wb, 1'b1));
        check(gap_err == gerr, "R7 inter-word null gap", 32'(gap_err - gerr), 32'd0);
        par_even = 1'b0;
    endtask

    task automatic t_full();
        logic [31:0] ws [0:8];
        int base = nw;
        bit ok, all_ok;
        xmit_en = 1'b0;
        for (int i = 0; i < 9; i++) ws[i] = 32'h1357_9BDF ^ (32'h0F0F_3C3C * (i + 1));
        for (int i = 0; i < 7; i++) load_word(ws[i]);
        @(negedge clk);
        check(fifo_full == 1'b0, "R8 not full at 7", 32'(fifo_full), 32'd0);
        load_word(ws[7]);
        @(negedge clk);
        check(fifo_full == 1'b1, "R8 full at 8", 32'(fifo_full), 32'd1);
        load_word(ws[8]);
        xmit_en = 1'b1;
        wait_ready(20000, ok);
        check(ok && nw == base + 8, "R8 write while full dropped", 32'(nw - base), 32'd8);
        all_ok = 1;
        for (int i = 0; i < 8; i++) if (wbuf[base+i] != exp_word(ws[i], 1'b0)) all_ok = 0;
        check(all_ok, "R8 queue order preserved", wbuf[base+7], exp_word(ws[7], 1'b0));
    endtask

    task automatic t_slow();
        logic [31:0] w = 32'h5A5A_C3C3;
        int base = nw, werr = width_err;
        bit ok;
        rate_slow = 1'b1; half_exp = 16; xmit_en = 1'b1;
        load_word(w);
        wait_ready(5000, ok);
        check(ok && wbuf[base] == exp_word(w, 1'b0), "R9 slow rate word", wbuf[base], exp_word(w, 1'b0));
        check(width_err == werr, "R9 slow half width 16", 32'(width_err - werr), 32'd0);
        rate_slow = 1'b0; half_exp = 2;
    endtask

    task automatic t_loop();
        logic [31:0] w = 32'h3C00_00F1;
        int base = nw, lk = leak;
        bit ok;
        loop_n = 1'b0; sel_lb = 1; xmit_en = 1'b1;
        load_word(w);
        wait_ready(2000, ok);
        check(ok && wbuf[base] == exp_word(w, 1'b0), "R10 loopback word", wbuf[base], exp_word(w, 1'b0));
        check(leak == lk, "R10 line pair quiet in loopback", 32'(leak - lk), 32'd0);
        loop_n = 1'b1; sel_lb = 0;
        cyc(2);
        lk = leak;
        load_word(~w);
        wait_ready(2000, ok);
        check(ok && wbuf[base+1] == exp_word(~w, 1'b0), "R10 line word after loopback", wbuf[base+1], exp_word(~w, 1'b0));
        check(leak == lk, "R10 loopback pair quiet in line mode", 32'(leak - lk), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_basic();
        t_even_pair();
        t_full();
        t_slow();
        t_loop();
        check(both_err == 0, "R5 never both pulses", 32'(both_err), 32'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule